// File: doc/BRIEF.md
# MDIO Management Register Engine

This block turns one host register write into one Clause 22 management access on a PHY's serial management pins. The host packs the whole transaction into a single 32-bit command word: the opcode, PHY address, register address and, for a write, the data. The engine then sends the frame on MDC/MDIO and controls a tri-state output enable so the PHY can drive the line during a read.

When the frame ends, the engine sets a ready flag in the same word. After a read, it also replaces the word's low half with the 16 bits the PHY returned. The host polls the ready flag. A one-cycle completion pulse is also provided for a neighbouring interrupt block.

MDC is the system clock divided by an even parameter and stays low while the engine is idle. MDIO is changed only as MDC falls and is sampled only as MDC rises.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: After reset the command word reads 0x1000_0000 (ready set, every other bit zero), and mdc_o, mdio_oe and done_o are low.
- R2: A host write taken while ready is 1 does three things. It stores write-data bits 27:0, clears ready in the following cycle and starts a frame. Bits 31:29 always read zero.
- R3: The frame is sent MSB first, in this order: 32 ones, start bits 01, opcode (word bits 27:26), PHY address (bits 25:21), register address (bits 20:16), two turnaround bits, then 16 data bits (bits 15:0).
- R4: For opcode 01 (write), the turnaround is driven as 10 and the data bits come from word bits 15:0. mdio_oe is high for all 64 bits, and bits 15:0 of the word are unchanged afterwards.
- R5: For opcode 10 (read), mdio_oe is high for bits 0 to 45 and low from the first turnaround bit (bit 46) to the end. The 16 values of mdio_i sampled during bits 48 to 63 are written MSB first into word bits 15:0 when the frame ends. Bits 27:16 are kept.
- R6: While a frame runs, mdc_o has a period of CLK_DIV clock cycles. mdio_o and mdio_oe change only on a falling edge of mdc_o, or when a frame is loaded. mdc_o stays low while idle.
- R7: Ready returns to 1, and done_o is high for exactly one cycle, CLK_DIV*64 cycles after the accepting write.
- R8: A host write while ready is 0 is ignored. The running frame, the stored fields and the result are unchanged, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the command word |
| reg_wdata | input | 32 | Command word written by the host |
| reg_rdata | output | 32 | Command word readback, with ready at bit 28 |
| done_o | output | 1 | One-cycle pulse when a frame completes |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data toward the PHY |
| mdio_oe | output | 1 | High while the engine drives MDIO |
| mdio_i | input | 1 | Serial data from the PHY |

## Verification
The assertions check the following on every cycle:
- done_o lasts exactly one cycle and coincides with ready;
- an accepted write drops ready;
- MDC is low whenever the engine is ready;
- MDIO and its enable hold still across every rising MDC edge;
- the stored address and opcode fields stay fixed for the whole time a frame is in flight.

Only the bench scenarios can show the rest:
- the full 64-bit serial content and the turnaround release, compared bit by bit against a scoreboard;
- the data returned by a modelled PHY;
- the exact completion latency;
- the MDC period;
- that a write issued mid-frame leaves no trace once the frame ends.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned RDY_BIT  = 28;
  localparam int unsigned OP_LO    = 26;
  localparam int unsigned PHY_LO   = 21;
  localparam int unsigned REG_LO   = 16;
  localparam int unsigned FIELD_W  = 28;

  typedef enum logic [1:0] {
    MDIO_OP_WR = 2'b01,
    MDIO_OP_RD = 2'b10
  } mdio_op_e;

  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_RUN  = 1'b1
  } eng_state_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int unsigned HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(HALF - 1));
  assign rise_o = run && wrap && !mdc_q;
  assign fall_o = run && wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] phy_ad,
  input  logic [ADDR_W-1:0] reg_ad,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise,
  input  logic              fall,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              finish_o,
  output logic              is_read_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int unsigned FRAME_BITS = PRE_LEN + 4 + 2 * ADDR_W + 2 + DATA_W;
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS);
  localparam int unsigned TA_POS     = PRE_LEN + 4 + 2 * ADDR_W;
  localparam int unsigned DATA_POS   = TA_POS + 2;
  localparam int unsigned LAST_POS   = FRAME_BITS - 1;

  eng_state_e              st_q, st_d;
  logic [FRAME_BITS-1:0]   sh_q, sh_d;
  logic [IDX_W-1:0]        idx_q, idx_d;
  logic [DATA_W-1:0]       rd_q, rd_d;
  logic                    rd_op_q, rd_op_d;
  logic                    last_bit;
  logic                    in_data;
  logic                    released;
  logic [1:0]              ta_bits;

  assign last_bit  = (idx_q == IDX_W'(LAST_POS));
  assign in_data   = (idx_q >= IDX_W'(DATA_POS));
  assign released  = rd_op_q && (idx_q >= IDX_W'(TA_POS));
  assign ta_bits   = (op == MDIO_OP_RD) ? 2'b11 : 2'b10;

  assign busy_o    = (st_q == ENG_RUN);
  assign finish_o  = busy_o && fall && last_bit;
  assign is_read_o = rd_op_q;
  assign rd_data_o = rd_q;
  assign mdio_o    = sh_q[FRAME_BITS-1];
  assign mdio_oe   = busy_o && !released;

  always_comb begin
    st_d    = st_q;
    sh_d    = sh_q;
    idx_d   = idx_q;
    rd_d    = rd_q;
    rd_op_d = rd_op_q;
    unique case (st_q)
      ENG_IDLE: begin
        if (start) begin
          st_d    = ENG_RUN;
          sh_d    = {{PRE_LEN{1'b1}}, 2'b01, op, phy_ad, reg_ad, ta_bits, wdata};
          idx_d   = '0;
          rd_op_d = (op == MDIO_OP_RD);
        end
      end
      ENG_RUN: begin
        if (rise && rd_op_q && in_data) begin
          rd_d = {rd_q[DATA_W-2:0], mdio_i};
        end
        if (fall) begin
          if (last_bit) begin
            st_d = ENG_IDLE;
          end else begin
            sh_d  = {sh_q[FRAME_BITS-2:0], 1'b1};
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      default: st_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ENG_IDLE;
      sh_q    <= '0;
      idx_q   <= '0;
      rd_q    <= '0;
      rd_op_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      sh_q    <= sh_d;
      idx_q   <= idx_d;
      rd_q    <= rd_d;
      rd_op_q <= rd_op_d;
    end
  end
endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned CLK_DIV = 8,
  parameter int unsigned PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              done_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int unsigned HALF = CLK_DIV / 2;

  logic [FIELD_W-1:0] fld_q, fld_d;
  logic               rdy_q, rdy_d;
  logic               done_q, done_d;
  logic               start;
  logic               busy, finish, is_read;
  logic               rise, fall;
  logic [DATA_W-1:0]  rd_data;
  logic [3:0]         unused_wr_hi;

  assign unused_wr_hi = reg_wdata[WORD_W-1:FIELD_W];
  assign start        = reg_wr && rdy_q;
  assign reg_rdata    = {3'b000, rdy_q, fld_q};
  assign done_o       = done_q;

  mdio_mdc_gen #(.HALF(HALF)) u_mdc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (busy),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_seq #(.PRE_LEN(PRE_LEN)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op        (reg_wdata[OP_LO+1:OP_LO]),
    .phy_ad    (reg_wdata[PHY_LO+ADDR_W-1:PHY_LO]),
    .reg_ad    (reg_wdata[REG_LO+ADDR_W-1:REG_LO]),
    .wdata     (reg_wdata[DATA_W-1:0]),
    .rise      (rise),
    .fall      (fall),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .finish_o  (finish),
    .is_read_o (is_read),
    .rd_data_o (rd_data),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
  );

  always_comb begin
    fld_d  = fld_q;
    rdy_d  = rdy_q;
    done_d = 1'b0;
    if (start) begin
      fld_d = reg_wdata[FIELD_W-1:0];
      rdy_d = 1'b0;
    end else if (finish) begin
      rdy_d  = 1'b1;
      done_d = 1'b1;
      if (is_read) begin
        fld_d[DATA_W-1:0] = rd_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q  <= '0;
      rdy_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      fld_q  <= fld_d;
      rdy_q  <= rdy_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [31:0] reg_rdata,
  input logic        done_o,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe
);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r7_done_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> reg_rdata[28]);

  a_r2_write_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_rdata[28]) |=> !reg_rdata[28]);

  a_r6_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[28] |-> !mdc_o);

  a_r6_stable_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc_o) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  a_r8_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[28] && $past(!reg_rdata[28])) |-> $stable(reg_rdata[27:16]));

  a_r1_bits_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:29] == 3'b000);
endmodule

bind mdio_mgmt_engine mdio_mgmt_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_rdata (reg_rdata),
  .done_o    (done_o),
  .mdc_o     (mdc_o),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe)
);

// File: tb/mdio_mgmt_engine_tb.sv
module mdio_mgmt_engine_tb_top;
  localparam int unsigned CLK_DIV = 8;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        done_o;
  logic        mdc_o;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i;

  int checks;
  int failures;
  bit finished;

  logic [63:0] exp_bits_q[$];
  logic [63:0] exp_mask_q[$];
  logic [15:0] phy_val;

  mdio_mgmt_engine #(.CLK_DIV(CLK_DIV)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .done_o    (done_o),
    .mdc_o     (mdc_o),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .mdio_i    (mdio_i)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // PHY model and frame monitor
  int          bitcnt = 0;
  logic [63:0] obs_bits;
  logic [63:0] obs_oe;
  realtime     t_prev;

  always @(posedge mdc_o) begin
    obs_bits[63-bitcnt] = mdio_o;
    obs_oe[63-bitcnt]   = mdio_oe;
    if (bitcnt == 1) begin
      chk(($realtime - t_prev) == realtime'(CLK_DIV * 20), "R6", "mdc period ns",
          64'(int'($realtime - t_prev)), 64'(CLK_DIV * 20));
    end
    t_prev = $realtime;
    bitcnt++;
    if (bitcnt == 64) begin
      logic [63:0] eb;
      logic [63:0] em;
      bitcnt = 0;
      if (exp_bits_q.size() == 0) begin
        chk(1'b0, "R8", "unexpected frame", obs_bits, 64'h0);
      end else begin
        eb = exp_bits_q.pop_front();
        em = exp_mask_q.pop_front();
        chk(obs_oe == em, "R5", "oe per bit", obs_oe, em);
        chk((obs_bits & em) == (eb & em), "R3", "frame bits", obs_bits & em, eb & em);
      end
    end
  end

  always @(negedge mdc_o) begin
    if (bitcnt >= 48) mdio_i = phy_val[63-bitcnt];
    else mdio_i = 1'b1;
  end

  function automatic logic [31:0] cmd(input logic [1:0] op, input logic [4:0] pa,
                                      input logic [4:0] ra, input logic [15:0] d);
    return {4'b0000, op, pa, ra, d};
  endfunction

  task automatic push_exp(input logic [1:0] op, input logic [4:0] pa,
                          input logic [4:0] ra, input logic [15:0] d);
    exp_bits_q.push_back({32'hFFFF_FFFF, 2'b01, op, pa, ra, 2'b10, d});
    if (op == 2'b10) exp_mask_q.push_back({{46{1'b1}}, 18'h0});
    else exp_mask_q.push_back({64{1'b1}});
  endtask

  task automatic host_write(input logic [31:0] w);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_wdata = w;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int cyc = 0;
    while (!done_o && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == 64 * CLK_DIV, req, "completion latency", 64'(cyc), 64'(64 * CLK_DIV));
    chk(reg_rdata[28] == 1'b1, req, "ready at done", 64'(reg_rdata[28]), 64'h1);
    @(negedge clk);
    chk(done_o == 1'b0, req, "done width", 64'(done_o), 64'h0);
  endtask

  task automatic run_frame(input logic [1:0] op, input logic [4:0] pa,
                           input logic [4:0] ra, input logic [15:0] d,
                           input logic [15:0] pv);
    logic [15:0] exp_d;
    phy_val = pv;
    push_exp(op, pa, ra, d);
    host_write(cmd(op, pa, ra, d) | 32'hF000_0000);
    chk(reg_rdata[28] == 1'b0, "R2", "ready cleared", 64'(reg_rdata), 64'h0);
    chk(reg_rdata[31:29] == 3'b000, "R2", "high bits zero", 64'(reg_rdata[31:29]), 64'h0);
    wait_done("R7");
    exp_d = (op == 2'b10) ? pv : d;
    chk(reg_rdata == (cmd(op, pa, ra, exp_d) | 32'h1000_0000),
        (op == 2'b10) ? "R5" : "R4", "word after frame",
        64'(reg_rdata), 64'(cmd(op, pa, ra, exp_d) | 32'h1000_0000));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    checks    = 0;
    failures  = 0;
    finished  = 1'b0;
    rst_n     = 1'b0;
    reg_wr    = 1'b0;
    reg_wdata = '0;
    mdio_i    = 1'b1;
    phy_val   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(reg_rdata == 32'h1000_0000, "R1", "reset word", 64'(reg_rdata), 64'h1000_0000);
    chk({mdc_o, mdio_oe, done_o} == 3'b000, "R1", "reset pins",
        64'({mdc_o, mdio_oe, done_o}), 64'h0);

    run_frame(2'b01, 5'h05, 5'h03, 16'hA5C3, 16'h0000);
    run_frame(2'b10, 5'h1F, 5'h00, 16'hDEAD, 16'h3C5A);
    run_frame(2'b10, 5'h00, 5'h1F, 16'h0000, 16'h8001);
    run_frame(2'b01, 5'h1A, 5'h15, 16'h0001, 16'hFFFF);

    // idle MDC stays low
    begin
      bit moved = 1'b0;
      repeat (3 * CLK_DIV) begin
        @(negedge clk);
        if (mdc_o || mdio_oe) moved = 1'b1;
      end
      chk(!moved, "R6", "mdc and oe quiet while idle", 64'(moved), 64'h0);
    end

    // write while busy is ignored (R8)
    phy_val = 16'h1234;
    push_exp(2'b10, 5'h02, 5'h04, 16'h0000);
    host_write(cmd(2'b10, 5'h02, 5'h04, 16'h0000));
    repeat (100) @(negedge clk);
    host_write(cmd(2'b01, 5'h11, 5'h0E, 16'h5555));
    chk(reg_rdata[27:0] == cmd(2'b10, 5'h02, 5'h04, 16'h0000) >> 0 && !reg_rdata[28],
        "R8", "fields kept after busy write", 64'(reg_rdata), 64'(cmd(2'b10, 5'h02, 5'h04, 16'h0)));
    begin
      int cyc = 0;
      while (!done_o && cyc < 2000) begin
        @(negedge clk);
        cyc++;
      end
    end
    chk(reg_rdata == (cmd(2'b10, 5'h02, 5'h04, 16'h1234) | 32'h1000_0000), "R8",
        "result after ignored write", 64'(reg_rdata),
        64'(cmd(2'b10, 5'h02, 5'h04, 16'h1234) | 32'h1000_0000));
    begin
      bit moved = 1'b0;
      repeat (4 * CLK_DIV) begin
        @(negedge clk);
        if (mdc_o || !reg_rdata[28]) moved = 1'b1;
      end
      chk(!moved, "R8", "no second frame", 64'(moved), 64'h0);
    end
    chk(exp_bits_q.size() == 0, "R3", "all frames seen", 64'(exp_bits_q.size()), 64'h0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule